// File: doc/BRIEF.md
# Table-driven 16-bit word scrambler

This block scrambles a stream of 16-bit words, one word per step, so that the output hides short-range correlation in a simple upstream generator such as an LFSR or a linear congruential source. It holds a 256-entry table of 16-bit entries. After reset, a fill sequence loads the table with its start pattern: each entry holds the 8-bit AES forward substitution of its index in the high byte and the inverse substitution in the low byte. Both bytes are computed in logic.

Once the fill is done, each accepted step reads two entries and forms the output from their four bytes. It then rotates the four bytes as one 32-bit word by an amount taken from the data, and writes the two halves back. Each step also keeps two of the read bytes. They are mixed into the addresses of the next step, which gives the table feedback. A rotation keeps the number of set bits, so the table's overall balance of ones and zeros never drifts.

Top module: `tabmix16`

## Requirements
- R1: After reset is released, `ready_o` is low for 255 rising clock edges and goes high on the 256th. It then stays high until the next reset. `out_valid_o` and `out_word_o` are 0 during reset.
- R2: At the end of the fill, the entry at index i holds {S(i), S⁻¹(i)} in bits [15:8] and [7:0]. S is the AES forward byte substitution and S⁻¹ is its inverse.
- R3: For a step with input word D, two addresses are used. The first is A = D[7:0] XOR Fk and the second is B = D[15:8] XOR Gk. Fk and Gk are the bytes F and G of the previous accepted step, and both are zero after reset.
- R4: Let E be bits [15:8] and F bits [7:0] of entry A, and G bits [15:8] and H bits [7:0] of entry B. The output is {E XOR H, F XOR G}. It appears on `out_word_o` with `out_valid_o` high in the cycle after the step is accepted.
- R5: The word {E,F,G,H} is rotated toward the MSB by (F[4:0] XOR G[4:0]) positions. Bits [31:16] of the result go back to entry A and bits [15:0] to entry B.
- R6: When A equals B, only the low half [15:0] of the rotated word is stored in that entry.
- R7: A step never changes the total number of set bits in the table, and never changes the number of set bits in the word it rewrites.
- R8: A strobe while `ready_o` is low has no effect. It raises no valid output and changes neither the table nor Fk/Gk.
- R9: Steps may be accepted on every consecutive clock, and each one sees the table as updated by the step before it.
- R10: Asserting reset during operation clears Fk/Gk and restarts the fill, which restores the start pattern of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Step strobe, accepted when ready_o is high |
| din_i | input | 16 | Input word D for this step |
| ready_o | output | 1 | Table fill complete |
| out_valid_o | output | 1 | out_word_o holds a fresh result |
| out_word_o | output | 16 | Scrambled output word |

## Verification
The assertions assume `step_i` and `din_i` are known and stable around each rising edge, and that reset is only released away from an edge. The bench changes every input on the falling edge and releases reset there. It strobes before the fill completes on purpose, so that the assertions see ignored steps. The address-collision case depends on the data, and random words reach it only rarely. The bench therefore also builds input words from the model's own Fk/Gk so that both addresses coincide.

// File: rtl/tabmix16_pkg.sv
`timescale 1ns/1ps
package tabmix16_pkg;
  localparam int BYTE_W  = 8;
  localparam int ENTRY_W = 2 * BYTE_W;
  localparam int DEPTH   = 1 << BYTE_W;
  localparam int WORD_W  = 2 * ENTRY_W;
  localparam int AMT_W   = $clog2(WORD_W);

  function automatic logic [7:0] rol8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // product in GF(2^8) with the reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = '0; x = a; y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  // multiplicative inverse as x^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq, acc;
    sq = x; acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sub_fwd(input logic [7:0] x);
    logic [7:0] s;
    s = gf_inv(x);
    return s ^ rol8(s, 1) ^ rol8(s, 2) ^ rol8(s, 3) ^ rol8(s, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sub_inv(input logic [7:0] y);
    return gf_inv(rol8(y, 1) ^ rol8(y, 3) ^ rol8(y, 6) ^ 8'h05);
  endfunction

  function automatic logic [AMT_W-1:0] rot_amount(input logic [7:0] f, input logic [7:0] g);
    return f[AMT_W-1:0] ^ g[AMT_W-1:0];
  endfunction
endpackage

// File: rtl/tabmix16_fill.sv
`timescale 1ns/1ps
module tabmix16_fill
  import tabmix16_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  output logic               fill_we,
  output logic [BYTE_W-1:0]  fill_addr,
  output logic [ENTRY_W-1:0] fill_data,
  output logic               ready
);
  logic [BYTE_W-1:0] idx;
  logic              busy;
  wire               last_idx = (idx == BYTE_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      busy  <= 1'b1;
      ready <= 1'b0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (last_idx) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end

  assign fill_we   = busy;
  assign fill_addr = idx;
  assign fill_data = {sub_fwd(idx), sub_inv(idx)};

  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r1_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_idx) |=> (ready && !busy));
endmodule

// File: rtl/tabmix16_table.sv
`timescale 1ns/1ps
module tabmix16_table
  import tabmix16_pkg::*;
(
  input  logic               clk,
  input  logic               fill_we,
  input  logic [BYTE_W-1:0]  fill_addr,
  input  logic [ENTRY_W-1:0] fill_data,
  input  logic               upd_we,
  input  logic [BYTE_W-1:0]  addr_a,
  input  logic [BYTE_W-1:0]  addr_b,
  input  logic [ENTRY_W-1:0] wr_a,
  input  logic [ENTRY_W-1:0] wr_b,
  output logic [ENTRY_W-1:0] rd_a,
  output logic [ENTRY_W-1:0] rd_b
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];

  // port B written last: on a collision its value is kept
  always_ff @(posedge clk) begin
    if (fill_we) begin
      mem[fill_addr] <= fill_data;
    end else if (upd_we) begin
      mem[addr_a] <= wr_a;
      mem[addr_b] <= wr_b;
    end
  end
endmodule

// File: rtl/tabmix16_rotator.sv
`timescale 1ns/1ps
module tabmix16_rotator #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [SW:0][W-1:0] st;
  assign st[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int K = 1 << s;
    assign st[s+1] = amt[s] ? {st[s][W-1-K:0], st[s][W-1:W-K]} : st[s];
  end

  assign dout = st[SW];

  always_comb begin
    a_r7_ones_kept: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: rtl/tabmix16.sv
`timescale 1ns/1ps
module tabmix16
  import tabmix16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic [15:0] din_i,
  output logic        ready_o,
  output logic        out_valid_o,
  output logic [15:0] out_word_o
);
  logic               fill_we;
  logic [BYTE_W-1:0]  fill_addr;
  logic [ENTRY_W-1:0] fill_data;
  logic [BYTE_W-1:0]  f_prev, g_prev;
  logic [BYTE_W-1:0]  addr_a, addr_b;
  logic [ENTRY_W-1:0] rd_a, rd_b;
  logic [WORD_W-1:0]  fused, rotated;
  logic [AMT_W-1:0]   amt;
  logic [BYTE_W-1:0]  byte_e, byte_f, byte_g, byte_h;
  wire                accept = step_i & ready_o;

  tabmix16_fill u_fill (
    .clk(clk), .rst_n(rst_n), .fill_we(fill_we), .fill_addr(fill_addr),
    .fill_data(fill_data), .ready(ready_o)
  );

  assign addr_a = din_i[BYTE_W-1:0] ^ f_prev;
  assign addr_b = din_i[ENTRY_W-1:BYTE_W] ^ g_prev;

  tabmix16_table u_tab (
    .clk(clk), .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .upd_we(accept), .addr_a(addr_a), .addr_b(addr_b),
    .wr_a(rotated[WORD_W-1:ENTRY_W]), .wr_b(rotated[ENTRY_W-1:0]),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  assign {byte_e, byte_f} = rd_a;
  assign {byte_g, byte_h} = rd_b;
  assign fused = {rd_a, rd_b};
  assign amt   = rot_amount(byte_f, byte_g);

  tabmix16_rotator #(.W(WORD_W)) u_rot (.din(fused), .amt(amt), .dout(rotated));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_prev      <= '0;
      g_prev      <= '0;
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        f_prev     <= byte_f;
        g_prev     <= byte_g;
        out_word_o <= {byte_e ^ byte_h, byte_f ^ byte_g};
      end
    end
  end

  a_r4_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid_o);
  a_r4_quiet_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid_o);
  a_r8_no_valid_early: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ready_o);
  a_r8_feedback_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(f_prev) && $stable(g_prev) && $stable(out_word_o)));
endmodule

// File: tb/tabmix16_test.sv
`timescale 1ns/1ps
module tabmix16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic [15:0] din_i = '0;
  logic        ready_o, out_valid_o;
  logic [15:0] out_word_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tabmix16 uut (.*);

  // bench model
  logic [7:0]  fwd [256];
  logic [7:0]  inv [256];
  logic [15:0] mdl [256];
  logic [7:0]  mf, mg;
  int          ones_start, collisions;

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] ex [255];
    int lg [256];
    logic [7:0] p, b, y;
    p = 8'h01;
    for (int i = 0; i < 255; i++) begin ex[i] = p; lg[p] = i; p = p ^ xt(p); end
    for (int x = 0; x < 256; x++) begin
      b = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      for (int i = 0; i < 8; i++)
        y[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
      fwd[x] = y;
    end
    for (int x = 0; x < 256; x++) inv[fwd[x]] = x[7:0];
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mdl[i] = {fwd[i], inv[i]};
    mf = 0; mg = 0;
  endtask

  function automatic int table_ones();
    int n = 0;
    for (int i = 0; i < 256; i++) n += $countones(mdl[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // returns expected output and advances the model
  task automatic model_step(input logic [15:0] d, output logic [15:0] r);
    logic [7:0] a, b, e, f, g, h;
    logic [31:0] w;
    logic [63:0] dd;
    int n;
    a = d[7:0] ^ mf; b = d[15:8] ^ mg;
    {e, f} = mdl[a]; {g, h} = mdl[b];
    if (a == b) collisions++;
    r = {e ^ h, f ^ g};
    n = (f ^ g) & 8'h1f;
    w = {e, f, g, h};
    dd = {w, w} << n;
    mdl[a] = dd[63:48];
    mdl[b] = dd[47:32];
    mf = f; mg = g;
  endtask

  task automatic do_step(input string req, input logic [15:0] d);
    logic [15:0] r;
    step_i = 1'b1; din_i = d;
    model_step(d, r);
    @(negedge clk);
    check({req, " valid"}, {31'b0, out_valid_o}, 32'd1);
    check(req, {16'b0, out_word_o}, {16'b0, r});
    step_i = 1'b0;
  endtask

  task automatic reset_and_fill(input bit poke);
    rst_n = 1'b0; step_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'b0, ready_o}, 0);
    check("R1 valid in reset", {31'b0, out_valid_o}, 0);
    check("R1 word in reset", {16'b0, out_word_o}, 0);
    rst_n = 1'b1;
    model_reset();
    for (int i = 1; i <= 256; i++) begin
      if (poke) begin step_i = 1'b1; din_i = 16'($urandom); end
      @(negedge clk);
      if (poke) check("R8 no valid before ready", {31'b0, out_valid_o}, 0);
      if (i == 255) check("R1 ready low at 255", {31'b0, ready_o}, 0);
      if (i == 256) check("R1 ready high at 256", {31'b0, ready_o}, 1);
    end
    step_i = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_1234));
    build_sbox();
    collisions = 0;
    reset_and_fill(1'b1);
    ones_start = table_ones();

    // R2/R3/R8: first steps see the fresh table, zero feedback
    do_step("R2 fresh table idx 00", 16'h0000);
    do_step("R3 feedback mix", 16'h53ca);
    // idle gap then sticky output check
    @(negedge clk);
    check("R4 valid drops when idle", {31'b0, out_valid_o}, 0);
    check("R1 ready stays", {31'b0, ready_o}, 1);

    // R6 directed collisions
    for (int k = 0; k < 8; k++) begin
      d[15:8] = 8'($urandom);
      d[7:0]  = d[15:8] ^ mg ^ mf;
      do_step("R6 collision", d);
    end

    // R9/R5 back-to-back random stream with periodic R7 checks
    for (int k = 0; k < 4000; k++) begin
      if (k % 97 == 0) begin
        d[15:8] = 8'($urandom); d[7:0] = d[15:8] ^ mg ^ mf;
      end else if (k % 13 == 0) d = 16'h0000;
      else d = 16'($urandom);
      do_step("R5 R9 stream", d);
      if (k % 500 == 0) check("R7 table ones conserved", table_ones(), ones_start);
    end
    check("R7 table ones final", table_ones(), ones_start);
    check("R6 collisions exercised", {31'b0, collisions > 0}, 1);

    // R10: reset mid-run restores the start pattern and clears feedback
    reset_and_fill(1'b0);
    do_step("R10 refilled table", 16'h0000);
    do_step("R10 stream", 16'hbeef);
    for (int k = 0; k < 200; k++) do_step("R10 R9 stream", 16'($urandom));
    check("R7 after refill", table_ones(), ones_start);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule